// File: doc/BRIEF.md
# Dithered Complementary PWM Generator

This block drives a complementary pair of outputs, a high-side `top_o` and a low-side `bot_o`, from one internal PWM waveform. To get finer resolution than one clock, it alternates between two settings that are one count apart. A dither timebase groups PWM periods into dither cycles. In the first N periods of each dither cycle the block uses the adjusted setting, and in the remaining periods it uses the base setting. Averaged over the dither cycle, the output lies between the two settings in proportion to the time spent on each.

There are two modes. In the frequency mode the period changes by one count and the duty is held at half. In the duty mode the period is fixed and the high time changes by one count. Each output passes through its own deadtime stage, which holds back every rising edge by a programmed number of ticks. A shutdown input gates both outputs off at once. After a shutdown, the outputs stay off until a re-arm pulse restarts the block from zero.

The configuration fields are captured by a write strobe into a pending set. The active set is updated from the pending set only when a dither cycle starts. All counting advances on cycles where the clock enable is high.

Top module: `dither_pwm`

## Requirements
- R1: Frequency mode (`cfg_mode`=0). A base period lasts P clocks and an adjusted period lasts P+1 clocks, where P is `cfg_period`; any value below 2 is treated as 2. In each period the internal waveform is high for the first floor(len/2) clocks and low for the remaining clocks.
- R2: Duty mode (`cfg_mode`=1). Every period lasts P clocks. The waveform is high for the first D clocks of a base period and D+1 clocks of an adjusted period, where D is `cfg_duty`. If that high count is P or more, the waveform stays high for the whole period.
- R3: A dither cycle is C periods long, where C is `cfg_dcyc` and 0 is treated as 1. The first N periods of each dither cycle use the adjusted setting, where N is `cfg_frac`. If N is C or more, every period uses the adjusted setting.
- R4: Over one dither cycle, the frequency mode lasts N(P+1)+(C-N)P clocks, and the duty mode is high for N(D+1)+(C-N)D clocks.
- R5: `top_o` follows the waveform and `bot_o` follows its inverse. Each output goes high only after its input has been high for `cfg_dead`+1 consecutive ticks, and goes low one tick after its input falls. The two outputs are never high together.
- R6: If `cfg_dead` is equal to or greater than a phase's length, the output for that phase stays low for the whole phase.
- R7: A `cfg_wr` pulse captures all six fields into a pending set. The pending set becomes active only at a re-arm or at the start of a dither cycle.
- R8: While `shutdown` is high, both outputs are low in the same cycle, without waiting for a clock edge.
- R9: After a shutdown, the outputs stay low until `shutdown` is low and `rearm` is pulsed. A re-arm pulse while `shutdown` is high is ignored. A re-arm restarts the period and dither counters from zero.
- R10: The counters and the deadtime stages advance only on clocks where `clk_en` is high.
- R11: After reset, both outputs stay low until the first re-arm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| clk_en | input | 1 | Tick enable for counting |
| cfg_wr | input | 1 | Capture the configuration fields into the pending set |
| cfg_mode | input | 1 | 0 = frequency mode, 1 = duty mode |
| cfg_period | input | CNT_W | Base period P |
| cfg_duty | input | CNT_W | Base high time D (duty mode) |
| cfg_dcyc | input | DC_W | Dither cycle length C, in periods |
| cfg_frac | input | DC_W | Number of adjusted periods N per dither cycle |
| cfg_dead | input | DT_W | Deadtime, in ticks |
| rearm | input | 1 | Restart pulse; loads the pending set and zeroes the counters |
| shutdown | input | 1 | Forces both outputs low |
| top_o | output | 1 | High-side output |
| bot_o | output | 1 | Low-side output |

## Verification
The bench sweeps every combination of period, dither length, adjusted-period count and deadtime on a small grid in both modes. It compares each output on every clock against a waveform it computes by walking the period sequence. The frequency sweep covers odd and even periods, so it separates the half-duty split from an off-by-one in the high time. Cases with N=0, N=C and N in between separate where the adjusted periods sit in the dither cycle. The duty sweep includes D values at and above P, and the deadtime sweep includes a value of 3 against phases of 2 and 3 clocks, which exercises the suppressed-pulse case of R6. Separate runs write a new configuration in the middle of a dither cycle, stretch time with a sparse clock enable, and walk through shutdown, an ignored re-arm and a restart, so that buffering, tick gating and the latching shutdown are each checked on their own.

// File: rtl/dither_pwm_pkg.sv
package dither_pwm_pkg;
  typedef enum logic {
    MODE_VFREQ = 1'b0,
    MODE_VDUTY = 1'b1
  } pwm_mode_e;
endpackage

// File: rtl/dither_pwm_timebase.sv
module dither_pwm_timebase
  import dither_pwm_pkg::*;
#(
  parameter int DC_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            restart_i,
  input  logic            period_end_i,
  input  logic [DC_W-1:0] cyc_i,
  input  logic [DC_W-1:0] frac_i,
  output logic            second_o,
  output logic            cycle_end_o
);
  logic [DC_W-1:0] pidx;

  function automatic logic [DC_W-1:0] last_idx(logic [DC_W-1:0] c);
    return (c == '0) ? '0 : c - 1'b1;
  endfunction

  assign cycle_end_o = period_end_i && (pidx == last_idx(cyc_i));
  assign second_o    = pidx < frac_i;

  always_ff @(posedge clk) begin
    if (rst || restart_i)  pidx <= '0;
    else if (period_end_i) pidx <= cycle_end_o ? '0 : pidx + 1'b1;
  end

  // R3
  dither_idx_range_chk: assert property (@(posedge clk) disable iff (rst)
    pidx <= last_idx(cyc_i));
endmodule

// File: rtl/dither_pwm_period.sv
module dither_pwm_period
  import dither_pwm_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart_i,
  input  logic             tick_i,
  input  pwm_mode_e        mode_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] duty_i,
  input  logic             second_i,
  output logic             raw_o,
  output logic             period_end_o
);
  localparam int LEN_W = CNT_W + 1;

  logic [LEN_W-1:0] pcnt;
  logic [LEN_W-1:0] len;
  logic [LEN_W-1:0] high;

  function automatic logic [LEN_W-1:0] phase_len(pwm_mode_e m, logic [CNT_W-1:0] p,
                                                 logic sec);
    logic [LEN_W-1:0] b;
    b = {1'b0, p} + ((m == MODE_VFREQ && sec) ? LEN_W'(1) : LEN_W'(0));
    if (b < LEN_W'(2)) b = LEN_W'(2);
    return b;
  endfunction

  function automatic logic [LEN_W-1:0] high_len(pwm_mode_e m, logic [LEN_W-1:0] l,
                                                logic [CNT_W-1:0] d, logic sec);
    if (m == MODE_VFREQ) return l >> 1;
    return {1'b0, d} + LEN_W'(sec);
  endfunction

  assign len          = phase_len(mode_i, period_i, second_i);
  assign high         = high_len(mode_i, len, duty_i, second_i);
  assign raw_o        = pcnt < high;
  assign period_end_o = tick_i && (pcnt == len - 1'b1);

  always_ff @(posedge clk) begin
    if (rst || restart_i) pcnt <= '0;
    else if (tick_i)      pcnt <= period_end_o ? '0 : pcnt + 1'b1;
  end

  // R1 R2
  period_range_chk: assert property (@(posedge clk) disable iff (rst)
    pcnt < len);

  // R1
  vf_tail_low_chk: assert property (@(posedge clk) disable iff (rst)
    (period_end_o && mode_i == MODE_VFREQ) |-> !raw_o);
endmodule

// File: rtl/dither_pwm_deadtime.sv
module dither_pwm_deadtime #(
  parameter int DT_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr_i,
  input  logic            tick_i,
  input  logic [DT_W-1:0] dead_i,
  input  logic            in_i,
  output logic            out_o
);
  logic [DT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      cnt   <= '0;
      out_o <= 1'b0;
    end else if (tick_i) begin
      if (!in_i) begin
        cnt   <= '0;
        out_o <= 1'b0;
      end else if (cnt == dead_i) begin
        out_o <= 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R5
  deadtime_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(out_o) |-> $past(in_i));
endmodule

// File: rtl/dither_pwm.sv
module dither_pwm
  import dither_pwm_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int DC_W  = 4,
  parameter int DT_W  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clk_en,
  input  logic             cfg_wr,
  input  logic             cfg_mode,
  input  logic [CNT_W-1:0] cfg_period,
  input  logic [CNT_W-1:0] cfg_duty,
  input  logic [DC_W-1:0]  cfg_dcyc,
  input  logic [DC_W-1:0]  cfg_frac,
  input  logic [DT_W-1:0]  cfg_dead,
  input  logic             rearm,
  input  logic             shutdown,
  output logic             top_o,
  output logic             bot_o
);
  typedef struct packed {
    pwm_mode_e        mode;
    logic [CNT_W-1:0] period;
    logic [CNT_W-1:0] duty;
    logic [DC_W-1:0]  dcyc;
    logic [DC_W-1:0]  frac;
    logic [DT_W-1:0]  dead;
  } cfg_t;

  cfg_t pend, act;
  logic running;
  logic restart;
  logic tick;
  logic raw;
  logic period_end;
  logic cycle_end;
  logic second;
  logic load_act;
  logic [1:0] dt_in;
  logic [1:0] dt_out;

  assign restart  = rearm && !shutdown;
  assign tick     = clk_en && running;
  assign load_act = restart || cycle_end;

  always_ff @(posedge clk) begin
    if (rst) pend <= '0;
    else if (cfg_wr) pend <= '{mode: pwm_mode_e'(cfg_mode), period: cfg_period,
                               duty: cfg_duty, dcyc: cfg_dcyc, frac: cfg_frac,
                               dead: cfg_dead};
  end

  always_ff @(posedge clk) begin
    if (rst)           act <= '0;
    else if (load_act) act <= pend;
  end

  always_ff @(posedge clk) begin
    if (rst || shutdown) running <= 1'b0;
    else if (restart)    running <= 1'b1;
  end

  dither_pwm_timebase #(.DC_W(DC_W)) timebase_i (
    .clk(clk), .rst(rst), .restart_i(restart), .period_end_i(period_end),
    .cyc_i(act.dcyc), .frac_i(act.frac), .second_o(second), .cycle_end_o(cycle_end)
  );

  dither_pwm_period #(.CNT_W(CNT_W)) period_i (
    .clk(clk), .rst(rst), .restart_i(restart), .tick_i(tick), .mode_i(act.mode),
    .period_i(act.period), .duty_i(act.duty), .second_i(second),
    .raw_o(raw), .period_end_o(period_end)
  );

  generate
    for (genvar g = 0; g < 2; g++) begin : g_dt
      if (g == 0) begin : g_hi
        assign dt_in[g] = raw && running;
      end else begin : g_lo
        assign dt_in[g] = !raw && running;
      end
      dither_pwm_deadtime #(.DT_W(DT_W)) dt_i (
        .clk(clk), .rst(rst), .clr_i(restart || !running), .tick_i(tick),
        .dead_i(act.dead), .in_i(dt_in[g]), .out_o(dt_out[g])
      );
    end
  endgenerate

  assign top_o = dt_out[0] && running && !shutdown;
  assign bot_o = dt_out[1] && running && !shutdown;

  // R5
  no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
    !(top_o && bot_o));

  // R8
  shutdown_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    shutdown |-> (!top_o && !bot_o));

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !running |-> (!top_o && !bot_o));

  // R7
  act_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !load_act |=> $stable(act));
endmodule

// File: tb/dither_pwm_tb_top.sv
module dither_pwm_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic clk_en = 1'b1;
  logic cfg_wr = 1'b0;
  logic cfg_mode = 1'b0;
  logic [7:0] cfg_period = '0;
  logic [7:0] cfg_duty = '0;
  logic [3:0] cfg_dcyc = '0;
  logic [3:0] cfg_frac = '0;
  logic [3:0] cfg_dead = '0;
  logic rearm = 1'b0;
  logic shutdown = 1'b0;
  logic top_o, bot_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int a_mode, a_per, a_duty, a_cyc, a_frac, a_dead;
  int b_mode, b_per, b_duty, b_cyc, b_frac;
  bit sw = 0;
  bit top_hist [512];

  always #5 clk = ~clk;

  dither_pwm dut_i (
    .clk(clk), .rst(rst), .clk_en(clk_en), .cfg_wr(cfg_wr), .cfg_mode(cfg_mode),
    .cfg_period(cfg_period), .cfg_duty(cfg_duty), .cfg_dcyc(cfg_dcyc),
    .cfg_frac(cfg_frac), .cfg_dead(cfg_dead), .rearm(rearm), .shutdown(shutdown),
    .top_o(top_o), .bot_o(bot_o)
  );

  function automatic int cl1(int c);
    return (c == 0) ? 1 : c;
  endfunction

  // Expected internal waveform at tick t, walking the period sequence.
  function automatic bit m_raw(int t);
    int k = 0;
    int rem = t;
    for (int guard = 0; guard < 100000; guard++) begin
      bit useb = sw && (k >= cl1(a_cyc));
      int md = useb ? b_mode : a_mode;
      int p = useb ? b_per : a_per;
      int d = useb ? b_duty : a_duty;
      int fr = useb ? b_frac : a_frac;
      int idx = useb ? (k - cl1(a_cyc)) % cl1(b_cyc) : k % cl1(a_cyc);
      int sec = (idx < fr) ? 1 : 0;
      int len = (md == 0) ? p + sec : p;
      int high;
      if (len < 2) len = 2;
      high = (md == 0) ? len / 2 : d + sec;
      if (rem < len) return rem < high;
      rem -= len;
      k++;
    end
    return 0;
  endfunction

  function automatic bit m_win(int m, bit pol);
    for (int j = 0; j <= a_dead; j++) begin
      if (m - j < 0) return 0;
      if (m_raw(m - j) != pol) return 0;
    end
    return 1;
  endfunction

  task automatic chk(bit got, bit exp, string tag, string what);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b", tag, what, got, exp);
    end
  endtask

  task automatic wr_cfg(int md, int p, int d, int c, int f, int dt);
    @(negedge clk);
    cfg_mode = md[0]; cfg_period = p[7:0]; cfg_duty = d[7:0];
    cfg_dcyc = c[3:0]; cfg_frac = f[3:0]; cfg_dead = dt[3:0]; cfg_wr = 1'b1;
    a_mode = md; a_per = p; a_duty = d; a_cyc = c; a_frac = f; a_dead = dt;
    sw = 0;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic run_cmp(int nsamp, string tag, bit slow_en, int wr_at);
    int n;
    rearm = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rearm = 1'b0;
    n = 0;
    top_hist[0] = top_o;
    chk(top_o, 1'b0, tag, "top after rearm");
    chk(bot_o, 1'b0, tag, "bot after rearm");
    for (int i = 1; i < nsamp; i++) begin
      clk_en = slow_en ? (i % 3 != 0) : 1'b1;
      cfg_wr = (i == wr_at);
      if (i == wr_at) begin
        cfg_mode = b_mode[0]; cfg_period = b_per[7:0]; cfg_duty = b_duty[7:0];
        cfg_dcyc = b_cyc[3:0]; cfg_frac = b_frac[3:0];
      end
      @(posedge clk);
      if (clk_en) n++;
      @(negedge clk);
      if (n < 512) top_hist[n] = top_o;
      chk(top_o, m_win(n - 1, 1'b1), tag, $sformatf("top n=%0d", n));
      chk(bot_o, m_win(n - 1, 1'b0), tag, $sformatf("bot n=%0d", n));
    end
    clk_en = 1'b1;
    cfg_wr = 1'b0;
  endtask

  function automatic int dead_pick(int i);
    return (i == 0) ? 0 : (i == 1) ? 1 : 3;
  endfunction

  initial begin
    int cnt;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R11: idle after reset even with a configuration written
    wr_cfg(0, 4, 0, 1, 0, 0);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      chk(top_o, 1'b0, "R11", "top idle after reset");
      chk(bot_o, 1'b0, "R11", "bot idle after reset");
    end

    // R1 R3 R5 R6: frequency-mode sweep
    for (int p = 4; p <= 7; p++)
      for (int c = 1; c <= 3; c++)
        for (int f = 0; f <= c; f++)
          for (int di = 0; di < 3; di++) begin
            wr_cfg(0, p, 0, c, f, dead_pick(di));
            run_cmp(60, "R1/R3/R5/R6", 1'b0, -1);
          end

    // R2 R3 R5 R6: duty-mode sweep, including D at and above P
    for (int di = 0; di < 4; di++)
      for (int c = 2; c <= 3; c++)
        for (int fi = 0; fi < 3; fi++)
          for (int dd = 0; dd < 2; dd++) begin
            int dv = (di == 0) ? 0 : (di == 1) ? 3 : (di == 2) ? 5 : 6;
            int fv = (fi == 0) ? 0 : (fi == 1) ? 1 : 3;
            wr_cfg(1, 6, dv, c, fv, dd * 2);
            run_cmp(60, "R2/R3/R5/R6", 1'b0, -1);
          end

    // R4: duty mode high count over one dither cycle: 1*3 + 3*2 = 9
    wr_cfg(1, 6, 2, 4, 1, 0);
    run_cmp(40, "R4", 1'b0, -1);
    cnt = 0;
    for (int i = 1; i <= 24; i++) cnt += top_hist[i];
    chk(cnt == 9, 1'b1, "R4", $sformatf("duty high clocks=%0d exp 9", cnt));

    // R4: frequency mode cycle 5+4+4 = 13 clocks, 4th rise at sample 14
    wr_cfg(0, 4, 0, 3, 1, 0);
    run_cmp(40, "R4", 1'b0, -1);
    cnt = 0;
    for (int i = 1; i < 40; i++)
      if (top_hist[i] && !top_hist[i-1]) begin
        cnt++;
        if (cnt == 4) chk(i == 14, 1'b1, "R4", $sformatf("4th rise at %0d exp 14", i));
      end

    // R7: new values written mid dither cycle apply from the next cycle
    wr_cfg(0, 4, 0, 2, 1, 0);
    b_mode = 0; b_per = 7; b_duty = 0; b_cyc = 1; b_frac = 0;
    sw = 1;
    run_cmp(50, "R7", 1'b0, 3);
    sw = 0;

    // R10: sparse clock enable
    wr_cfg(0, 5, 0, 2, 1, 1);
    run_cmp(90, "R10", 1'b1, -1);

    // R8 R9: shutdown, ignored rearm, restart from zero
    wr_cfg(1, 6, 6, 1, 0, 0);
    run_cmp(10, "R2", 1'b0, -1);
    chk(top_o, 1'b1, "R8", "top high before shutdown");
    shutdown = 1'b1;
    #1;
    chk(top_o, 1'b0, "R8", "top at shutdown");
    chk(bot_o, 1'b0, "R8", "bot at shutdown");
    @(negedge clk);
    rearm = 1'b1;
    @(negedge clk);
    rearm = 1'b0;
    shutdown = 1'b0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      chk(top_o, 1'b0, "R9", "top latched off");
      chk(bot_o, 1'b0, "R9", "bot latched off");
    end
    wr_cfg(0, 5, 0, 2, 1, 0);
    run_cmp(30, "R9", 1'b0, -1);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule